// File: doc/BRIEF.md
# Multi-Mode Timer Interrupt Status Register

This block keeps the sticky interrupt flags for a bank of three timer channels. Each channel's counter supplies its current operating mode (stopped, interval, pulse generator or watchdog) and single-cycle strobes that fire when the count equals compare value A or compare value B. A strobe sets its flag only when the channel is in the mode that owns that flag. The flag then stays set until software clears it.

Software reaches each channel's 32-bit status word over a simple register bus. The word for channel n sits at address 0xF004 + n * 0x100. Reads are combinational. A write clears every implemented flag whose data bit is 0 and leaves every flag whose data bit is 1 unchanged. Which flags exist depends on the channel: the watchdog flag is present on channel 2 only, and the two pulse-generator flags are present on channels 0 and 1 only. Each channel drives one interrupt line, which is high while any of its implemented flags is set.

Top module: `tis_top`

## Requirements
- R1: Bits 31 to 4 of every status word read as 0, even after a write of all ones.
- R2: Bit 0 is set one clock after a compare-A strobe arrives while the channel mode is interval (mode code 2'b01). This holds on every channel.
- R3: On channels 0 and 1, in pulse-generator mode (code 2'b10), a compare-A strobe sets bit 1 and a compare-B strobe sets bit 2. On channel 2 these bits stay 0 and read as 0.
- R4: On channel 2, in watchdog mode (code 2'b11), a compare-A strobe sets bit 3. On channels 0 and 1 bit 3 stays 0 and reads as 0.
- R5: All flags are 0 after reset, and a set flag stays set until it is cleared by a write.
- R6: A write to a channel's word clears each implemented flag whose data bit is 0. A data bit of 1 leaves its flag unchanged. Data bits 31 to 4 are ignored.
- R7: When a set strobe and a write-0 clear reach the same flag in the same cycle, the flag ends up set.
- R8: A strobe that arrives while the channel is in a mode that does not own that flag leaves the flag unchanged. This includes stopped mode (code 2'b00) and compare-B strobes outside pulse-generator mode.
- R9: irq[n] is 1 exactly when at least one implemented flag of channel n is 1, in the same cycle the flags change.
- R10: Channel n decodes only the address 0xF004 + n * 0x100. A read of any other address returns 0, and a write to any other address changes no flag. A write to one channel leaves the other channels unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ch_mode | input | 6 | Mode of channel n in bits [2n+1:2n]: 00 stopped, 01 interval, 10 pulse generator, 11 watchdog |
| match_a | input | 3 | Compare-A match strobe, one bit per channel |
| match_b | input | 3 | Compare-B match strobe, one bit per channel |
| bus_sel | input | 1 | Bus access select |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 16 | Byte address |
| bus_wdata | input | 32 | Write data; a 0 in bits [3:0] clears the matching flag |
| bus_rdata | output | 32 | Read data for the addressed status word, 0 when not selected or unmapped |
| irq | output | 3 | Interrupt request, one line per channel |

## Verification
Flags are registered. A strobe or a clear is therefore seen in the read data and on irq after the next rising edge, while a read returns the current flags in the same cycle as its address. The bench drives each stimulus just after a falling edge and holds it across one rising edge. It then advances its own model and compares irq at the following falling edge. Reads are issued in the low phase with no edge in between and are compared one time step later against the model state.

// File: rtl/tis_pkg.sv
package tis_pkg;

  typedef enum logic [1:0] {
    MODE_STOP     = 2'b00,
    MODE_INTERVAL = 2'b01,
    MODE_PULSE    = 2'b10,
    MODE_WDOG     = 2'b11
  } tmode_e;

  localparam int FLAG_W  = 4;
  localparam int BIT_IVL = 0;
  localparam int BIT_PGA = 1;
  localparam int BIT_PGB = 2;
  localparam int BIT_WDG = 3;

  // Which flags a channel implements; the watchdog channel trades the
  // pulse flags for the watchdog flag.
  function automatic logic [FLAG_W-1:0] impl_mask(input int ch, input int wd_ch);
    logic [FLAG_W-1:0] m;
    m          = '0;
    m[BIT_IVL] = 1'b1;
    if (ch == wd_ch) begin
      m[BIT_WDG] = 1'b1;
    end else begin
      m[BIT_PGA] = 1'b1;
      m[BIT_PGB] = 1'b1;
    end
    return m;
  endfunction

  // Raw set requests for a mode and its strobes, before masking.
  function automatic logic [FLAG_W-1:0] match_events(input tmode_e mode,
                                                     input logic   hit_a,
                                                     input logic   hit_b);
    logic [FLAG_W-1:0] e;
    e = '0;
    unique case (mode)
      MODE_INTERVAL: e[BIT_IVL] = hit_a;
      MODE_PULSE: begin
        e[BIT_PGA] = hit_a;
        e[BIT_PGB] = hit_b;
      end
      MODE_WDOG:     e[BIT_WDG] = hit_a;
      default:       e = '0;
    endcase
    return e;
  endfunction

  // Clear requests: data bit 0 on an implemented flag clears it.
  function automatic logic [FLAG_W-1:0] clear_events(input logic              wr,
                                                     input logic [FLAG_W-1:0] wd,
                                                     input logic [FLAG_W-1:0] mask);
    return wr ? (~wd & mask) : '0;
  endfunction

  // Set has priority over clear.
  function automatic logic [FLAG_W-1:0] next_flags(input logic [FLAG_W-1:0] cur,
                                                   input logic [FLAG_W-1:0] set_v,
                                                   input logic [FLAG_W-1:0] clr_v);
    return (cur & ~clr_v) | set_v;
  endfunction

endpackage

// File: rtl/tis_addr_dec.sv
module tis_addr_dec #(
  parameter int ADDR_W = 16,
  parameter int NUM_CH = 3,
  parameter int BASE   = 'hF004,
  parameter int STRIDE = 'h100
) (
  input  logic              sel,
  input  logic [ADDR_W-1:0] addr,
  output logic [NUM_CH-1:0] hit
);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dec
    localparam logic [ADDR_W-1:0] CH_ADDR = ADDR_W'(BASE + c * STRIDE);
    assign hit[c] = sel && (addr == CH_ADDR);
  end

endmodule

// File: rtl/tis_chan_flags.sv
module tis_chan_flags
  import tis_pkg::*;
#(
  parameter int CH_IDX = 0,
  parameter int WD_CH  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  tmode_e            mode,
  input  logic              match_a,
  input  logic              match_b,
  input  logic              wr_hit,
  input  logic [FLAG_W-1:0] wdata,
  output logic [FLAG_W-1:0] flags,
  output logic [FLAG_W-1:0] set_evt,
  output logic [FLAG_W-1:0] clr_evt
);

  localparam logic [FLAG_W-1:0] MASK = impl_mask(CH_IDX, WD_CH);

  logic [FLAG_W-1:0] flags_q;

  assign set_evt = match_events(mode, match_a, match_b) & MASK;
  assign clr_evt = clear_events(wr_hit, wdata, MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= next_flags(flags_q, set_evt, clr_evt);
  end

  assign flags = flags_q;

endmodule

// File: rtl/tis_rd_mux.sv
module tis_rd_mux
  import tis_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int DATA_W = 32
) (
  input  logic [NUM_CH-1:0]        hit,
  input  logic [NUM_CH*FLAG_W-1:0] flag_vec,
  output logic [DATA_W-1:0]        rdata
);

  always_comb begin
    rdata = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      if (hit[c]) rdata[FLAG_W-1:0] = rdata[FLAG_W-1:0] | flag_vec[c*FLAG_W +: FLAG_W];
    end
  end

endmodule

// File: rtl/tis_top.sv
module tis_top
  import tis_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WD_CH  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int BASE   = 'hF004,
  parameter int STRIDE = 'h100
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*NUM_CH-1:0] ch_mode,
  input  logic [NUM_CH-1:0]   match_a,
  input  logic [NUM_CH-1:0]   match_b,
  input  logic                bus_sel,
  input  logic                bus_wr,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic [DATA_W-1:0]   bus_wdata,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [NUM_CH-1:0]   irq
);

  localparam int VEC_W = NUM_CH * FLAG_W;

  logic [NUM_CH-1:0] ch_hit;
  logic [VEC_W-1:0]  flag_vec;
  logic [VEC_W-1:0]  set_vec;
  logic [VEC_W-1:0]  clr_vec;
  logic              wdata_rsv_unused;

  assign wdata_rsv_unused = ^bus_wdata[DATA_W-1:FLAG_W];

  tis_addr_dec #(
    .ADDR_W (ADDR_W),
    .NUM_CH (NUM_CH),
    .BASE   (BASE),
    .STRIDE (STRIDE)
  ) u_dec (
    .sel  (bus_sel),
    .addr (bus_addr),
    .hit  (ch_hit)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    tis_chan_flags #(
      .CH_IDX (c),
      .WD_CH  (WD_CH)
    ) u_flags (
      .clk     (clk),
      .rst_n   (rst_n),
      .mode    (tmode_e'(ch_mode[2*c +: 2])),
      .match_a (match_a[c]),
      .match_b (match_b[c]),
      .wr_hit  (ch_hit[c] && bus_wr),
      .wdata   (bus_wdata[FLAG_W-1:0]),
      .flags   (flag_vec[c*FLAG_W +: FLAG_W]),
      .set_evt (set_vec[c*FLAG_W +: FLAG_W]),
      .clr_evt (clr_vec[c*FLAG_W +: FLAG_W])
    );
    assign irq[c] = |flag_vec[c*FLAG_W +: FLAG_W];
  end

  tis_rd_mux #(
    .NUM_CH (NUM_CH),
    .DATA_W (DATA_W)
  ) u_rd (
    .hit      (ch_hit),
    .flag_vec (flag_vec),
    .rdata    (bus_rdata)
  );

endmodule

// File: rtl/tis_chk.sv
module tis_chk
  import tis_pkg::*;
#(
  parameter int NUM_CH = 3,
  parameter int WD_CH  = 2,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic [2*NUM_CH-1:0]        ch_mode,
  input logic [NUM_CH-1:0]          match_a,
  input logic [NUM_CH-1:0]          match_b,
  input logic                       bus_sel,
  input logic                       bus_wr,
  input logic [ADDR_W-1:0]          bus_addr,
  input logic [DATA_W-1:0]          bus_wdata,
  input logic [DATA_W-1:0]          bus_rdata,
  input logic [NUM_CH-1:0]          irq,
  input logic [NUM_CH*FLAG_W-1:0]   flags,
  input logic [NUM_CH*FLAG_W-1:0]   set_evt,
  input logic [NUM_CH*FLAG_W-1:0]   clr_evt,
  input logic [NUM_CH-1:0]          addr_hit
);

  logic [ADDR_W-1:0] addr_unused;
  assign addr_unused = bus_addr;

  AST_RSV_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rdata[DATA_W-1:FLAG_W] == '0);  // R1

  AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !(|addr_hit)) |-> (bus_rdata == '0));  // R10

  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_evt)) == $past(flags & ~clr_evt)));  // R5

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_evt & clr_evt)) |=> ((flags & $past(set_evt & clr_evt)) == $past(set_evt & clr_evt)));  // R7

  for (genvar c = 0; c < NUM_CH; c++) begin : g_c
    AST_INTERVAL_SET: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_mode[2*c +: 2] == MODE_INTERVAL && match_a[c]) |=> flags[c*FLAG_W + BIT_IVL]);  // R2

    AST_IVL_WRONG_MODE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flags[c*FLAG_W + BIT_IVL]) |-> $past(ch_mode[2*c +: 2] == MODE_INTERVAL && match_a[c]));  // R8

    AST_ONES_NO_EFFECT: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_wr && addr_hit[c] && bus_wdata[FLAG_W-1:0] == '1 && set_evt[c*FLAG_W +: FLAG_W] == '0)
      |=> $stable(flags[c*FLAG_W +: FLAG_W]));  // R6

    AST_IRQ_RISE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq[c]) |-> $past(|set_evt[c*FLAG_W +: FLAG_W]));  // R9

    AST_IRQ_FALL: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq[c]) |-> $past(bus_sel && bus_wr && addr_hit[c]));  // R9

    if (c == WD_CH) begin : g_wd
      AST_WDOG_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode[2*c +: 2] == MODE_WDOG && match_a[c]) |=> flags[c*FLAG_W + BIT_WDG]);  // R4
      AST_NO_PULSE_BITS: assert property (@(posedge clk) disable iff (!rst_n)
        flags[c*FLAG_W + BIT_PGB -: 2] == 2'b00);  // R3
    end else begin : g_pg
      AST_PULSE_A_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode[2*c +: 2] == MODE_PULSE && match_a[c]) |=> flags[c*FLAG_W + BIT_PGA]);  // R3
      AST_PULSE_B_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (ch_mode[2*c +: 2] == MODE_PULSE && match_b[c]) |=> flags[c*FLAG_W + BIT_PGB]);  // R3
      AST_NO_WDOG_BIT: assert property (@(posedge clk) disable iff (!rst_n)
        !flags[c*FLAG_W + BIT_WDG]);  // R4
    end
  end

endmodule

bind tis_top tis_chk #(
  .NUM_CH (NUM_CH),
  .WD_CH  (WD_CH),
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ch_mode   (ch_mode),
  .match_a   (match_a),
  .match_b   (match_b),
  .bus_sel   (bus_sel),
  .bus_wr    (bus_wr),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq       (irq),
  .flags     (flag_vec),
  .set_evt   (set_vec),
  .clr_evt   (clr_vec),
  .addr_hit  (ch_hit)
);

// File: tb/sim_tis_top.sv
module sim_tis_top;

  localparam int CLK_PERIOD = 10;
  localparam int WDOG_LIMIT = 200000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [5:0]  ch_mode = '0;
  logic [2:0]  match_a = '0;
  logic [2:0]  match_b = '0;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [15:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [2:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;
  logic [3:0] mdl [0:2];

  always #(CLK_PERIOD/2) clk = ~clk;

  tis_top u0 (
    .clk(clk), .rst_n(rst_n), .ch_mode(ch_mode), .match_a(match_a), .match_b(match_b),
    .bus_sel(bus_sel), .bus_wr(bus_wr), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  function automatic logic [15:0] ch_addr(input int c);
    return 16'hF004 + 16'(c) * 16'h0100;
  endfunction

  function automatic int addr_ch(input logic [15:0] a);
    for (int c = 0; c < 3; c++) if (a == ch_addr(c)) return c;
    return -1;
  endfunction

  function automatic bit has_bit(input int c, input int b);
    if (c == 2) return (b == 0) || (b == 3);
    return b < 3;
  endfunction

  function automatic logic [3:0] want_set(input int c, input logic [1:0] m,
                                          input logic a, input logic b);
    logic [3:0] r = '0;
    if (m == 2'b01) r[0] = a;
    if (m == 2'b10 && c != 2) begin r[1] = a; r[2] = b; end
    if (m == 2'b11 && c == 2) r[3] = a;
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic model_update();
    for (int c = 0; c < 3; c++) begin
      logic [3:0] s = want_set(c, ch_mode[2*c +: 2], match_a[c], match_b[c]);
      bit wr_me = bus_sel && bus_wr && (addr_ch(bus_addr) == c);
      for (int b = 0; b < 4; b++) begin
        if (s[b]) mdl[c][b] = 1'b1;
        else if (wr_me && has_bit(c, b) && !bus_wdata[b]) mdl[c][b] = 1'b0;
      end
    end
  endtask

  task automatic idle();
    ch_mode = '0; match_a = '0; match_b = '0;
    bus_sel = 1'b0; bus_wr = 1'b0; bus_wdata = '0;
  endtask

  task automatic step();
    @(posedge clk);
    #1 model_update();
    @(negedge clk);
    idle();
  endtask

  task automatic rd_chk(input logic [15:0] a, input logic [31:0] exp, input string tag);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 chk(tag, bus_rdata, exp);
    bus_sel = 1'b0;
  endtask

  task automatic wr(input logic [15:0] a, input logic [31:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    step();
  endtask

  task automatic strobe(input int c, input logic [1:0] m, input logic a, input logic b);
    ch_mode[2*c +: 2] = m; match_a[c] = a; match_b[c] = b;
    step();
  endtask

  task automatic clear_all();
    for (int c = 0; c < 3; c++) wr(ch_addr(c), 32'h0);
  endtask

  initial begin
    repeat (WDOG_LIMIT) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R5 watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    for (int c = 0; c < 3; c++) mdl[c] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R5 reset state
    for (int c = 0; c < 3; c++) rd_chk(ch_addr(c), 32'h0, "R5 reset word");
    chk("R5 reset irq", {29'b0, irq}, 32'h0);

    // R2 interval set, R9 irq
    strobe(0, 2'b01, 1'b1, 1'b0);
    rd_chk(ch_addr(0), 32'h1, "R2 interval A ch0");
    chk("R9 irq ch0 high", {29'b0, irq}, 32'h1);
    repeat (3) step();
    rd_chk(ch_addr(0), 32'h1, "R5 sticky ch0");

    // R6 write one no effect, write zero clears
    wr(ch_addr(0), 32'hFFFF_FFFF);
    rd_chk(ch_addr(0), 32'h1, "R6 write ones keeps");
    wr(ch_addr(0), 32'hFFFF_FFFE);
    rd_chk(ch_addr(0), 32'h0, "R6 write zero clears");
    chk("R9 irq ch0 low", {29'b0, irq}, 32'h0);

    // R3 pulse flags on ch1
    strobe(1, 2'b10, 1'b1, 1'b0);
    rd_chk(ch_addr(1), 32'h2, "R3 pulse A ch1");
    strobe(1, 2'b10, 1'b0, 1'b1);
    rd_chk(ch_addr(1), 32'h6, "R3 pulse B ch1");
    wr(ch_addr(1), 32'hFFFF_FFFB);
    rd_chk(ch_addr(1), 32'h2, "R6 partial clear ch1");
    // R10 unmapped writes and reads
    wr(16'hF000, 32'h0); wr(16'hF008, 32'h0); wr(16'hF304, 32'h0); wr(16'hF184, 32'h0);
    rd_chk(ch_addr(1), 32'h2, "R10 unmapped write ignored");
    rd_chk(16'hF008, 32'h0, "R10 unmapped read F008");
    rd_chk(16'hF304, 32'h0, "R10 unmapped read F304");
    wr(ch_addr(0), 32'h0);
    rd_chk(ch_addr(1), 32'h2, "R10 other channel untouched");
    clear_all();

    // R3 pulse absent on ch2
    strobe(2, 2'b10, 1'b1, 1'b1);
    rd_chk(ch_addr(2), 32'h0, "R3 no pulse bits ch2");
    chk("R3 irq ch2 stays low", {29'b0, irq}, 32'h0);

    // R4 watchdog
    strobe(2, 2'b11, 1'b1, 1'b0);
    rd_chk(ch_addr(2), 32'h8, "R4 watchdog ch2");
    chk("R9 irq ch2", {29'b0, irq}, 32'h4);
    strobe(0, 2'b11, 1'b1, 1'b1);
    rd_chk(ch_addr(0), 32'h0, "R4 no watchdog ch0");
    clear_all();

    // R8 wrong mode
    strobe(0, 2'b01, 1'b0, 1'b1);
    strobe(0, 2'b00, 1'b1, 1'b1);
    strobe(1, 2'b11, 1'b1, 1'b1);
    rd_chk(ch_addr(0), 32'h0, "R8 wrong mode ch0");
    rd_chk(ch_addr(1), 32'h0, "R8 wrong mode ch1");
    strobe(0, 2'b10, 1'b1, 1'b0);
    rd_chk(ch_addr(0), 32'h2, "R8 pulse A leaves bit0");

    // R7 set wins, same cycle clear
    ch_mode[1:0] = 2'b01; match_a[0] = 1'b1;
    wr(ch_addr(0), 32'h0);
    rd_chk(ch_addr(0), 32'h1, "R7 set wins over clear");

    // R1 reserved bits
    wr(ch_addr(0), 32'hFFFF_FFFF);
    strobe(1, 2'b10, 1'b1, 1'b1);
    for (int c = 0; c < 3; c++) begin
      bus_sel = 1'b1; bus_addr = ch_addr(c);
      #1 chk("R1 reserved read zero", bus_rdata >> 4, 32'h0);
      bus_sel = 1'b0;
    end

    // random phase
    for (int i = 0; i < 3000; i++) begin
      for (int c = 0; c < 3; c++) begin
        ch_mode[2*c +: 2] = 2'($urandom_range(3, 0));
        match_a[c] = ($urandom_range(3, 0) == 0);
        match_b[c] = ($urandom_range(3, 0) == 0);
      end
      if ($urandom_range(4, 0) == 0) begin
        int pick = $urandom_range(5, 0);
        bus_sel = 1'b1; bus_wr = 1'b1;
        bus_addr = (pick < 3) ? ch_addr(pick) : (pick == 3 ? 16'hF304 : 16'hF104 + 16'h4);
        bus_wdata = $urandom();
      end
      step();
      chk("R9 random irq", {29'b0, irq}, {29'b0, |mdl[2], |mdl[1], |mdl[0]});
      for (int c = 0; c < 3; c++) rd_chk(ch_addr(c), {28'b0, mdl[c]}, "R10 random word");
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule